// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a bank of independent interval timers. Each channel has its own clock divider and its own down-counter. Software starts a channel by loading a nonzero count. The count then falls by one at the divided rate. When it reaches zero it stays there, and the channel's sticky done flag is set. There is no separate enable and no compare register. Writing the load value is the only thing that arms a channel.

Each channel has its own divide select and interrupt enable. A load port sets the count of one channel. A write-one-to-clear vector clears done flags. A read port returns the live count of the selected channel. Each channel has an interrupt line, which is its done flag gated by that channel's enable. The bus bridge and the interrupt controller that sit around the block are not part of it.

Top module: `ivt_timer_bank`

## Requirements
- R1: After reset every count reads 0, every done flag is 0 and every interrupt is 0.
- R2: A load of a nonzero value V to a channel makes its count read V in the next cycle. The channel then runs.
- R3: The 4-bit divide select N makes a running count fall by exactly one every 2^N clock cycles. The count therefore reaches 0 exactly V·2^N cycles after the load edge, for N from 0 to 15.
- R4: When a running count reaches 0, the channel's done flag is set in that same cycle. The count then stays at 0 until the next load.
- R5: A load of zero stops the channel at once. The count reads 0 and the done flag is not set by it.
- R6: A load to a running channel restarts the count from the new value and resets the divider phase. The next step therefore comes a full 2^N cycles later.
- R7: The done flag is sticky. Writing 1 to bit i of `flag_clr` clears flag i, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq[i]` equals `flag[i]` AND the channel's interrupt enable, which is written through the configuration port together with the divide select.
- R9: A load, configuration or clear aimed at one channel leaves the count, flag and settings of every other channel unchanged.
- R10: `rd_count` shows, in the same cycle, the count of the channel selected by `rd_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load strobe |
| ld_ch | input | IDX_W | Channel addressed by the load |
| ld_value | input | CNT_W | Count to load; zero stops the channel |
| cfg_valid | input | 1 | Configuration strobe |
| cfg_ch | input | IDX_W | Channel addressed by the configuration |
| cfg_div | input | PSC_W | Divide select N (rate = clock / 2^N) |
| cfg_irq_en | input | 1 | Interrupt enable written with cfg_div |
| flag_clr | input | NUM_CH | Write-one-to-clear for the done flags |
| rd_ch | input | IDX_W | Channel whose count appears on rd_count |
| rd_count | output | CNT_W | Live count of channel rd_ch |
| flag | output | NUM_CH | Sticky done flags |
| irq | output | NUM_CH | Interrupt lines, flag AND enable |

## Verification
The timing of the count is tried at several divide selects. A select of 0 counts every cycle. A select of 2 shows whether the divider runs at all. A select of 3 with a reload partway through a divided period separates a reset divider phase from a free-running one. The large selects 10 and 15 check the full divider width. Loads of zero land on a running channel to show that the stop raises no flag. A clear is timed to the very edge at which a count expires, which exposes which of the two wins. Several channels run at once with different loads to show that they do not disturb each other, and the enables are toggled while flags are held to show the interrupt gating.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
   localparam int unsigned MAX_PSC_W = 5;

   function automatic logic [31:0] span_mask(input int unsigned sel);
      return (32'd1 << sel) - 32'd1;
   endfunction
endpackage

// File: rtl/ivt_prescaler.sv
`timescale 1ns/1ps
module ivt_prescaler #(
   parameter int unsigned PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   localparam int unsigned PH_W = (1 << PSC_W) - 1;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] mask;

   assign mask = PH_W'(ivt_pkg::span_mask(int'(div)));
   assign tick = run && ((phase_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || !run) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
module ivt_channel #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_value,
   input  logic             cfg,
   input  logic [PSC_W-1:0] cfg_div,
   input  logic             cfg_en,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             irq
);
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic             en_q;
   logic [PSC_W-1:0] div_q;
   logic             tick;
   logic             expire;

   ivt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ld),
      .run     (run_q),
      .div     (div_q),
      .tick    (tick)
   );

   assign expire = !ld && run_q && tick && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
         en_q   <= 1'b0;
         div_q  <= '0;
      end else begin
         if (cfg) begin
            div_q <= cfg_div;
            en_q  <= cfg_en;
         end
         if (ld) begin
            cnt_q <= ld_value;
            run_q <= (ld_value != '0);
         end else if (run_q && tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
         end
         if (expire)   flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
      end
   end

   assign count = cnt_q;
   assign flag  = flag_q;
   assign irq   = flag_q && en_q;
endmodule

// File: rtl/ivt_timer_bank.sv
`timescale 1ns/1ps
module ivt_timer_bank #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 4,
   localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [IDX_W-1:0]  ld_ch,
   input  logic [CNT_W-1:0]  ld_value,
   input  logic              cfg_valid,
   input  logic [IDX_W-1:0]  cfg_ch,
   input  logic [PSC_W-1:0]  cfg_div,
   input  logic              cfg_irq_en,
   input  logic [NUM_CH-1:0] flag_clr,
   input  logic [IDX_W-1:0]  rd_ch,
   output logic [CNT_W-1:0]  rd_count,
   output logic [NUM_CH-1:0] flag,
   output logic [NUM_CH-1:0] irq
);
   if (NUM_CH < 1) begin : g_bad_num_ch
      $error("ivt_timer_bank: NUM_CH must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("ivt_timer_bank: CNT_W must be at least 2");
   end
   if (PSC_W < 1 || PSC_W > ivt_pkg::MAX_PSC_W) begin : g_bad_psc_w
      $error("ivt_timer_bank: PSC_W out of range");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit_ld;
      logic hit_cfg;
      assign hit_ld  = ld_valid  && (ld_ch  == IDX_W'(i));
      assign hit_cfg = cfg_valid && (cfg_ch == IDX_W'(i));

      ivt_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld       (hit_ld),
         .ld_value (ld_value),
         .cfg      (hit_cfg),
         .cfg_div  (cfg_div),
         .cfg_en   (cfg_irq_en),
         .clr      (flag_clr[i]),
         .count    (cnt_all[i]),
         .flag     (flag[i]),
         .irq      (irq[i])
      );
   end

   if (NUM_CH == (1 << IDX_W)) begin : g_rd_full
      assign rd_count = cnt_all[rd_ch];
   end else begin : g_rd_guarded
      assign rd_count = (rd_ch < IDX_W'(NUM_CH)) ? cnt_all[rd_ch] : '0;
   end
endmodule

// File: rtl/ivt_timer_bank_chk.sv
`timescale 1ns/1ps
module ivt_timer_bank_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned IDX_W  = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ld_valid,
   input logic [IDX_W-1:0]              ld_ch,
   input logic [CNT_W-1:0]              ld_value,
   input logic [NUM_CH-1:0]             flag_clr,
   input logic [NUM_CH-1:0]             flag,
   input logic [NUM_CH-1:0]             irq,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all
);
   logic [NUM_CH-1:0] ld_hit;
   always_comb begin
      for (int i = 0; i < NUM_CH; i++) ld_hit[i] = ld_valid && (ld_ch == IDX_W'(i));
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ld_hit[i] |=> cnt_all[i] == $past(ld_value));
      assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !ld_hit[i] |=> (cnt_all[i] == $past(cnt_all[i]) || cnt_all[i] == $past(cnt_all[i]) - 1'b1));
      assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_all[i] == '0 && !ld_hit[i]) |=> cnt_all[i] == '0);
      assert_flag_at_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> (cnt_all[i] == '0 && $past(cnt_all[i]) == CNT_W'(1)));
      assert_zero_load_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_hit[i] && ld_value == '0) |=> (cnt_all[i] == '0 && !$rose(flag[i])));
      assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[i] && !flag_clr[i]) |=> flag[i]);
      assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> flag[i]);
   end
endmodule

bind ivt_timer_bank ivt_timer_bank_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_valid (ld_valid),
   .ld_ch    (ld_ch),
   .ld_value (ld_value),
   .flag_clr (flag_clr),
   .flag     (flag),
   .irq      (irq),
   .cnt_all  (cnt_all)
);

// File: tb/ivt_timer_bank_tb_top.sv
`timescale 1ns/1ps
module ivt_timer_bank_tb_top;
   localparam int NCH = 4;
   localparam int CW  = 16;
   localparam int PW  = 4;
   localparam int IW  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 1'b0;
   logic [IW-1:0] ld_ch = '0;
   logic [CW-1:0] ld_value = '0;
   logic          cfg_valid = 1'b0;
   logic [IW-1:0] cfg_ch = '0;
   logic [PW-1:0] cfg_div = '0;
   logic          cfg_irq_en = 1'b0;
   logic [NCH-1:0] flag_clr = '0;
   logic [IW-1:0] rd_ch = '0;
   logic [CW-1:0] rd_count;
   logic [NCH-1:0] flag;
   logic [NCH-1:0] irq;

   always #2 clk = ~clk;

   ivt_timer_bank #(.NUM_CH(NCH), .CNT_W(CW), .PSC_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_value(ld_value),
      .cfg_valid(cfg_valid), .cfg_ch(cfg_ch), .cfg_div(cfg_div), .cfg_irq_en(cfg_irq_en),
      .flag_clr(flag_clr), .rd_ch(rd_ch), .rd_count(rd_count), .flag(flag), .irq(irq)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_req  = "R1";

   int m_cnt [NCH];
   int m_pre [NCH];
   int m_run [NCH];
   int m_flag[NCH];
   int m_div [NCH];
   int m_en  [NCH];

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      for (int i = 0; i < NCH; i++) begin
         bit hit_ld  = ld_valid && (int'(ld_ch) == i);
         bit hit_cfg = cfg_valid && (int'(cfg_ch) == i);
         int mask    = (1 << m_div[i]) - 1;
         bit tick    = m_run[i] != 0 && ((m_pre[i] & mask) == mask);
         bit set_f   = !hit_ld && tick && m_cnt[i] == 1;
         if (hit_ld) begin
            m_cnt[i] = int'(ld_value);
            m_run[i] = (ld_value != 0);
            m_pre[i] = 0;
         end else if (m_run[i] != 0) begin
            m_pre[i] = (m_pre[i] + 1) % 32768;
            if (tick) begin
               m_cnt[i] = m_cnt[i] - 1;
               if (m_cnt[i] == 0) m_run[i] = 0;
            end
         end
         if (set_f) m_flag[i] = 1;
         else if (flag_clr[i]) m_flag[i] = 0;
         if (hit_cfg) begin
            m_div[i] = int'(cfg_div);
            m_en[i]  = cfg_irq_en;
         end
      end
   endtask

   task automatic compare_all();
      for (int i = 0; i < NCH; i++) begin
         rd_ch = IW'(i);
         #0.1;
         check(int'(rd_count) == m_cnt[i], cur_req, $sformatf("ch%0d count (R10 read)", i), int'(rd_count), m_cnt[i]);
         check(int'(flag[i]) == m_flag[i], cur_req, $sformatf("ch%0d flag", i), int'(flag[i]), m_flag[i]);
         check(int'(irq[i]) == (m_flag[i] & m_en[i]), cur_req, $sformatf("ch%0d irq (R8)", i),
               int'(irq[i]), m_flag[i] & m_en[i]);
      end
   endtask

   task automatic cycle(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         compare_all();
         ld_valid = 1'b0; cfg_valid = 1'b0; flag_clr = '0;
      end
   endtask

   task automatic do_load(input int ch, input int v);
      ld_valid = 1'b1; ld_ch = IW'(ch); ld_value = CW'(v);
      cycle();
   endtask

   task automatic do_cfg(input int ch, input int dv, input bit en);
      cfg_valid = 1'b1; cfg_ch = IW'(ch); cfg_div = PW'(dv); cfg_irq_en = en;
      cycle();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, cur_req, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin
         m_cnt[i] = 0; m_pre[i] = 0; m_run[i] = 0; m_flag[i] = 0; m_div[i] = 0; m_en[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      compare_all();

      cur_req = "R2";
      do_cfg(0, 0, 1'b1);
      do_load(0, 5);
      cycle(3);
      check(flag[0] == 1'b0, "R4", "ch0 flag before expiry", int'(flag[0]), 0);
      cycle(3);
      check(flag[0] == 1'b1 && irq[0] == 1'b1, "R4", "ch0 flag after 5 ticks", int'(flag[0]), 1);

      cur_req = "R3";
      do_cfg(1, 2, 1'b0);
      do_load(1, 3);
      cycle(14);

      cur_req = "R7";
      flag_clr = 4'b1110;
      cycle();
      check(flag[0] == 1'b1, "R7", "ch0 flag with clr bit 0", int'(flag[0]), 1);
      flag_clr = 4'b0001;
      cycle();
      check(flag[0] == 1'b0, "R7", "ch0 flag after clr", int'(flag[0]), 0);

      cur_req = "R5";
      do_load(2, 100);
      cycle(10);
      do_load(2, 0);
      cycle(5);
      check(flag[2] == 1'b0, "R5", "ch2 flag after zero load", int'(flag[2]), 0);

      cur_req = "R6";
      do_cfg(3, 3, 1'b1);
      do_load(3, 4);
      cycle(13);
      do_load(3, 2);
      cycle(20);

      cur_req = "R7";
      do_load(0, 2);
      cycle();
      flag_clr = 4'b0001;
      cycle();
      check(flag[0] == 1'b1, "R7", "ch0 set wins over same-cycle clear", int'(flag[0]), 1);

      cur_req = "R8";
      do_cfg(1, 2, 1'b1);
      cycle(2);
      do_cfg(0, 0, 1'b0);
      cycle(2);

      cur_req = "R9";
      flag_clr = 4'b1111;
      cycle();
      do_cfg(0, 10, 1'b1);
      do_cfg(3, 15, 1'b1);
      do_load(3, 1);
      do_load(0, 3);
      do_load(1, 7);
      do_cfg(2, 1, 1'b1);
      do_load(2, 9);
      cycle(33000);
      check(flag == 4'b1111, "R9", "all flags after concurrent runs", int'(flag), 15);

      summary();
      $finish;
   end
endmodule